// File: doc/BRIEF.md
# Bank-Switched Register Window

This block is a slave register file seen by a host through a window of sixteen byte addresses. Most offsets in the window are shared among several register banks. A bank select register chooses which bank they reach. That register sits at byte offset 14 and is reachable from every bank. The host can therefore see many more registers than the window has ports.

The host bus is 16 bits wide with byte lanes, and it also carries a 32-bit form that spans two neighbouring 16-bit registers. Each access names a byte address and a size code. Reads are combinational on the address, the size and the current bank. A write is taken on the rising clock edge while the write strobe is high.

Behind the decode, each bank holds plain 16-bit storage words at offsets 0x0 to 0xC. A parameter mask marks any of these words as reserved. With the default mask, bank 0 offset 0xC and all of bank 2 are reserved. The network logic and packet memory that such registers would normally drive are outside this block.

Top module: `bankwin_regs`

## Requirements
- R1: After reset the bank is 0, a word read at offset 14 returns 0x3300, and every storage word reads 0x0000.
- R2: A write that reaches the low byte of offset 14 loads the bank from data bits [1:0]. For a 32-bit access at offset 12 the bits are [17:16]. This holds in every bank.
- R3: Bits 15:8 of offset 14 always read 0x33 and bits 7:2 always read zero. Writes to any bit except the bank field are ignored, including a byte write at offset 15.
- R4: A byte read (size code 0) at an odd offset returns bits 15:8 of the word at the even offset below it. At an even offset it returns bits 7:0. The byte appears on rdata[7:0] and rdata[31:8] is zero.
- R5: A byte write takes wdata[7:0] into the lane picked as in R4 and leaves the other byte of that word unchanged.
- R6: A 16-bit access (size code 1) ignores address bit 0. It uses rdata[15:0] or wdata[15:0], and rdata[31:16] reads zero.
- R7: A 32-bit access (size code 2) ignores address bits [1:0]. Bits [15:0] map to the word at the offset rounded down to a multiple of 4, and bits [31:16] map to the word two bytes above it, for both read and write.
- R8: A write to a storage offset changes only the word at that offset in the current bank. The same offset in other banks keeps its value.
- R9: Reserved words read zero and writes to them have no effect. These are bank 0 offset 0xC and bank 2 offsets 0x0 to 0xC.
- R10: Size code 3 is no access: rdata reads zero and a write changes nothing.
- R11: A write becomes visible only after the rising edge at which the strobe is high. Before that edge, a read of the same word shows the old value.
- R12: A 32-bit write at offset 12 stores its low half into offset 12 of the bank that was current before the edge, while its upper half loads the new bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_size | input | 2 | 0 byte, 1 word, 2 double word, 3 none |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data, steered as in R4 to R7 |
| bus_rdata | output | 32 | Combinational read data |

## Verification
Read data has no register on its path, so a read result is due in the same cycle as its address and size. The bench sets them at the falling edge and samples 5 ns later. A write is due one rising edge after the strobe is raised at a falling edge. The bench drops the strobe at the next falling edge and makes its read after that, so the value it compares has passed exactly one register. The R11 test samples the old value in the half cycle before the capturing edge and the new value just after it. This pins the write to that edge.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_NONE  = 2'd3
   } acc_size_e;

   localparam int unsigned LANE_W = 8;
   localparam int unsigned WORD_W = 16;
   localparam int unsigned BUS_W  = 32;

endpackage

// File: rtl/bankwin_decode.sv
module bankwin_decode
   import bankwin_pkg::*;
#(
   parameter int unsigned WIN_BITS  = 4,
   parameter int unsigned BANK_BITS = 2
) (
   input  logic [WIN_BITS-1:0]                       addr,
   input  acc_size_e                                 size,
   input  logic                                      wr,
   input  logic [BUS_W-1:0]                          wdata,
   output logic [WIN_BITS-2:0]                       idx_lo,
   output logic [WIN_BITS-2:0]                       idx_hi,
   output logic [(2**(WIN_BITS-1))-2:0][1:0]         wbe,
   output logic [(2**(WIN_BITS-1))-2:0][WORD_W-1:0]  wword,
   output logic                                      bsel_we,
   output logic [BANK_BITS-1:0]                      bsel_wd
);
   localparam int unsigned NUM_WORDS = 2 ** (WIN_BITS - 1);
   localparam int unsigned NUM_STORE = NUM_WORDS - 1;
   localparam int unsigned IDX_W     = WIN_BITS - 1;
   localparam logic [IDX_W-1:0] BSEL_IDX = IDX_W'(NUM_WORDS - 1);

   logic [1:0]        be_lo, be_hi;
   logic [WORD_W-1:0] d_lo, d_hi;
   logic              wide;

   always_comb begin
      idx_lo = addr[WIN_BITS-1:1];
      idx_hi = addr[WIN_BITS-1:1];
      be_lo  = 2'b00;
      be_hi  = 2'b00;
      d_lo   = wdata[WORD_W-1:0];
      d_hi   = wdata[BUS_W-1:WORD_W];
      wide   = 1'b0;
      case (size)
         SZ_BYTE: begin
            be_lo = addr[0] ? 2'b10 : 2'b01;
            d_lo  = {2{wdata[LANE_W-1:0]}};
         end
         SZ_WORD: begin
            be_lo = 2'b11;
         end
         SZ_DWORD: begin
            idx_lo = {addr[WIN_BITS-1:2], 1'b0};
            idx_hi = {addr[WIN_BITS-1:2], 1'b1};
            be_lo  = 2'b11;
            be_hi  = 2'b11;
            wide   = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      for (int k = 0; k < NUM_STORE; k++) begin
         wbe[k]   = 2'b00;
         wword[k] = d_lo;
         if (wr && idx_lo == IDX_W'(k)) begin
            wbe[k] = be_lo;
         end
         if (wr && wide && idx_hi == IDX_W'(k)) begin
            wbe[k]   = be_hi;
            wword[k] = d_hi;
         end
      end
      bsel_we = 1'b0;
      bsel_wd = d_lo[BANK_BITS-1:0];
      if (wr && idx_lo == BSEL_IDX && be_lo[0]) begin
         bsel_we = 1'b1;
      end
      if (wr && wide && idx_hi == BSEL_IDX) begin
         bsel_we = 1'b1;
         bsel_wd = d_hi[BANK_BITS-1:0];
      end
   end

endmodule

// File: rtl/bankwin_bsel.sv
module bankwin_bsel
   import bankwin_pkg::*;
#(
   parameter int unsigned      BANK_BITS = 2,
   parameter logic [LANE_W-1:0] ID_CODE  = 8'h33
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [BANK_BITS-1:0] wd,
   output logic [BANK_BITS-1:0] bank,
   output logic [WORD_W-1:0]    rd_word
);
   localparam int unsigned PAD_W = LANE_W - BANK_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank <= '0;
      end else if (we) begin
         bank <= wd;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_word = {ID_CODE, {PAD_W{1'b0}}, bank};
      end else begin : g_nopad
         assign rd_word = {ID_CODE, bank};
      end
   endgenerate

endmodule

// File: rtl/bankwin_bank.sv
module bankwin_bank
   import bankwin_pkg::*;
#(
   parameter int unsigned        NUM_STORE = 7,
   parameter logic [NUM_STORE-1:0] RSV     = '0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 sel,
   input  logic [NUM_STORE-1:0][1:0]            wbe,
   input  logic [NUM_STORE-1:0][WORD_W-1:0]     wword,
   output logic [NUM_STORE-1:0][WORD_W-1:0]     rd
);

   generate
      for (genvar k = 0; k < NUM_STORE; k++) begin : g_word
         logic [WORD_W-1:0] q;
         logic              live;
         assign live = sel && !RSV[k];
         for (genvar b = 0; b < 2; b++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q[b*LANE_W +: LANE_W] <= '0;
               end else if (live && wbe[k][b]) begin
                  q[b*LANE_W +: LANE_W] <= wword[k][b*LANE_W +: LANE_W];
               end
            end
         end
         assign rd[k] = RSV[k] ? '0 : q;
      end
   endgenerate

endmodule

// File: rtl/bankwin_regs.sv
module bankwin_regs
   import bankwin_pkg::*;
#(
   parameter int unsigned  WIN_BITS  = 4,
   parameter int unsigned  BANK_BITS = 2,
   parameter logic [7:0]   ID_CODE   = 8'h33,
   parameter logic [63:0]  RSV_MASK  = 64'h0000_0000_001F_C040
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WIN_BITS-1:0]  bus_addr,
   input  logic [1:0]           bus_size,
   input  logic                 bus_wr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata
);
   localparam int unsigned NUM_WORDS = 2 ** (WIN_BITS - 1);
   localparam int unsigned NUM_STORE = NUM_WORDS - 1;
   localparam int unsigned NUM_BANKS = 2 ** BANK_BITS;
   localparam int unsigned IDX_W     = WIN_BITS - 1;

   generate
      if (WIN_BITS < 3 || WIN_BITS > 8) begin : g_bad_win
         $error("bankwin_regs: WIN_BITS out of range");
      end
      if (BANK_BITS < 1 || BANK_BITS > 8) begin : g_bad_bank
         $error("bankwin_regs: BANK_BITS out of range");
      end
      if (NUM_BANKS * NUM_STORE > 64) begin : g_bad_mask
         $error("bankwin_regs: reserved mask too narrow");
      end
   endgenerate

   acc_size_e size;
   assign size = acc_size_e'(bus_size);

   logic [IDX_W-1:0]                     idx_lo, idx_hi;
   logic [NUM_STORE-1:0][1:0]            wbe;
   logic [NUM_STORE-1:0][WORD_W-1:0]     wword;
   logic                                 bsel_we;
   logic [BANK_BITS-1:0]                 bsel_wd;
   logic [BANK_BITS-1:0]                 bank_q;
   logic [WORD_W-1:0]                    bsel_rd;

   bankwin_decode #(
      .WIN_BITS  (WIN_BITS),
      .BANK_BITS (BANK_BITS)
   ) u_decode (
      .addr    (bus_addr),
      .size    (size),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .idx_lo  (idx_lo),
      .idx_hi  (idx_hi),
      .wbe     (wbe),
      .wword   (wword),
      .bsel_we (bsel_we),
      .bsel_wd (bsel_wd)
   );

   bankwin_bsel #(
      .BANK_BITS (BANK_BITS),
      .ID_CODE   (ID_CODE)
   ) u_bsel (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bsel_we),
      .wd      (bsel_wd),
      .bank    (bank_q),
      .rd_word (bsel_rd)
   );

   logic [NUM_BANKS-1:0][NUM_STORE-1:0][WORD_W-1:0] bank_rd;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel;
         assign sel = (bank_q == BANK_BITS'(b));
         bankwin_bank #(
            .NUM_STORE (NUM_STORE),
            .RSV       (RSV_MASK[b*NUM_STORE +: NUM_STORE])
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel),
            .wbe   (wbe),
            .wword (wword),
            .rd    (bank_rd[b])
         );
      end
   endgenerate

   logic [NUM_WORDS-1:0][WORD_W-1:0] word_rd;
   logic [WORD_W-1:0]                w_lo, w_hi;

   assign word_rd[NUM_STORE-1:0] = bank_rd[bank_q];
   assign word_rd[NUM_WORDS-1]   = bsel_rd;
   assign w_lo = word_rd[idx_lo];
   assign w_hi = word_rd[idx_hi];

   always_comb begin
      case (size)
         SZ_BYTE:  bus_rdata = {24'h0, bus_addr[0] ? w_lo[15:8] : w_lo[7:0]};
         SZ_WORD:  bus_rdata = {16'h0, w_lo};
         SZ_DWORD: bus_rdata = {w_hi, w_lo};
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/bankwin_chk.sv
module bankwin_chk #(
   parameter int unsigned WIN_BITS  = 4,
   parameter int unsigned BANK_BITS = 2,
   parameter logic [7:0]  ID_CODE   = 8'h33,
   parameter logic [63:0] RSV_MASK  = 64'h0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [WIN_BITS-1:0]  bus_addr,
   input logic [1:0]           bus_size,
   input logic                 bus_wr,
   input logic [31:0]          bus_wdata,
   input logic [31:0]          bus_rdata,
   input logic [BANK_BITS-1:0] bank_q
);
   localparam int unsigned NUM_STORE = 2 ** (WIN_BITS - 1) - 1;
   localparam logic [WIN_BITS-1:0] BSEL_ADDR = WIN_BITS'(2 ** WIN_BITS - 2);

   logic                 hit_lo;
   logic [BANK_BITS-1:0] new_bank;
   logic                 rsv_word;

   assign hit_lo = bus_wr &&
      ((bus_size == 2'd0 && bus_addr == BSEL_ADDR) ||
       (bus_size == 2'd1 && bus_addr[WIN_BITS-1:1] == BSEL_ADDR[WIN_BITS-1:1]) ||
       (bus_size == 2'd2 && bus_addr[WIN_BITS-1:2] == BSEL_ADDR[WIN_BITS-1:2]));
   assign new_bank = (bus_size == 2'd2) ? bus_wdata[16 +: BANK_BITS] : bus_wdata[BANK_BITS-1:0];
   assign rsv_word = (bus_addr[WIN_BITS-1:1] != BSEL_ADDR[WIN_BITS-1:1]) &&
                     RSV_MASK[32'(bank_q) * NUM_STORE + 32'(bus_addr[WIN_BITS-1:1])];

   AST_ID_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size == 2'd1 && bus_addr[WIN_BITS-1:1] == BSEL_ADDR[WIN_BITS-1:1])
      |-> (bus_rdata[15:8] == ID_CODE && bus_rdata[7:BANK_BITS] == '0)); // R3

   AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lo |=> bank_q == $past(new_bank)); // R2

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_lo |=> $stable(bank_q)); // R3

   AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_size == 2'd0 |-> bus_rdata[31:8] == 24'h0); // R4

   AST_WORD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_size == 2'd1 |-> bus_rdata[31:16] == 16'h0); // R6

   AST_NONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_size == 2'd3 |-> bus_rdata == 32'h0); // R10

   AST_RSV_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size == 2'd1 && rsv_word) |-> bus_rdata == 32'h0); // R9

   AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!bus_wr) && $stable(bus_addr) && $stable(bus_size)) |-> $stable(bus_rdata)); // R11

endmodule

bind bankwin_regs bankwin_chk #(
   .WIN_BITS  (WIN_BITS),
   .BANK_BITS (BANK_BITS),
   .ID_CODE   (ID_CODE),
   .RSV_MASK  (RSV_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_size  (bus_size),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bank_q    (bank_q)
);

// File: tb/bankwin_regs_tb.sv
module bankwin_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [1:0]  bus_size = 2'd1;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bankwin_regs u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   // entry: {req, is_write, size, addr, wdata, expected}
   localparam int NV = 38;
   localparam logic [74:0] VEC [NV] = '{
      {4'd6,  1'b1, 2'd1, 4'h0, 32'h0000_1234, 32'h0},          // R6 word write
      {4'd6,  1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_1234},
      {4'd5,  1'b1, 2'd0, 4'h1, 32'h0000_00AB, 32'h0},          // R5 upper lane
      {4'd5,  1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_AB34},
      {4'd4,  1'b0, 2'd0, 4'h1, 32'h0,         32'h0000_00AB},  // R4 odd
      {4'd4,  1'b0, 2'd0, 4'h0, 32'h0,         32'h0000_0034},  // R4 even
      {4'd5,  1'b1, 2'd0, 4'h0, 32'h0000_00CD, 32'h0},
      {4'd6,  1'b0, 2'd1, 4'h1, 32'h0,         32'h0000_ABCD},  // R6 bit0 ignored
      {4'd7,  1'b1, 2'd2, 4'h6, 32'h5566_7788, 32'h0},          // R7
      {4'd7,  1'b0, 2'd2, 4'h5, 32'h0,         32'h5566_7788},
      {4'd7,  1'b0, 2'd1, 4'h6, 32'h0,         32'h0000_5566},
      {4'd2,  1'b1, 2'd1, 4'hE, 32'h0000_FFFD, 32'h0},          // R2 bank 1
      {4'd3,  1'b0, 2'd1, 4'hE, 32'h0,         32'h0000_3301},  // R3
      {4'd8,  1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_0000},  // R8
      {4'd8,  1'b1, 2'd1, 4'h0, 32'h0000_BEEF, 32'h0},
      {4'd8,  1'b1, 2'd1, 4'hC, 32'h0000_0F0F, 32'h0},
      {4'd8,  1'b0, 2'd1, 4'hC, 32'h0,         32'h0000_0F0F},
      {4'd2,  1'b1, 2'd0, 4'hE, 32'h0000_0000, 32'h0},          // bank 0 by byte
      {4'd8,  1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_ABCD},
      {4'd9,  1'b1, 2'd1, 4'hC, 32'h0000_1111, 32'h0},          // R9
      {4'd9,  1'b0, 2'd1, 4'hC, 32'h0,         32'h0000_0000},
      {4'd3,  1'b1, 2'd0, 4'hF, 32'h0000_0002, 32'h0},
      {4'd3,  1'b0, 2'd1, 4'hE, 32'h0,         32'h0000_3300},
      {4'd3,  1'b0, 2'd0, 4'hF, 32'h0,         32'h0000_0033},
      {4'd10, 1'b1, 2'd3, 4'h0, 32'h0000_FFFF, 32'h0},          // R10
      {4'd10, 1'b0, 2'd3, 4'h0, 32'h0,         32'h0000_0000},
      {4'd10, 1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_ABCD},
      {4'd2,  1'b1, 2'd1, 4'hE, 32'h0000_0002, 32'h0},
      {4'd9,  1'b1, 2'd1, 4'h2, 32'h0000_7777, 32'h0},
      {4'd9,  1'b0, 2'd1, 4'h2, 32'h0,         32'h0000_0000},
      {4'd7,  1'b0, 2'd2, 4'hC, 32'h0,         32'h3302_0000},
      {4'd2,  1'b1, 2'd1, 4'hE, 32'h0000_0001, 32'h0},
      {4'd12, 1'b1, 2'd2, 4'hC, 32'h0003_AAAA, 32'h0},          // R12
      {4'd12, 1'b0, 2'd1, 4'hE, 32'h0,         32'h0000_3303},
      {4'd12, 1'b0, 2'd1, 4'hC, 32'h0,         32'h0000_0000},
      {4'd2,  1'b1, 2'd1, 4'hE, 32'h0000_0001, 32'h0},
      {4'd12, 1'b0, 2'd1, 4'hC, 32'h0,         32'h0000_AAAA},
      {4'd8,  1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_BEEF}
   };

   task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_size  = s;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic do_read(input logic [3:0] a, input logic [1:0] s, output logic [31:0] q);
      @(negedge clk);
      bus_addr = a;
      bus_size = s;
      bus_wr   = 1'b0;
      #5;
      q = bus_rdata;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      logic [31:0] q;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      do_read(4'hE, 2'd1, q); check(1, q, 32'h0000_3300);
      do_read(4'h0, 2'd1, q); check(1, q, 32'h0000_0000);
      do_read(4'h8, 2'd2, q); check(1, q, 32'h0000_0000);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][70]) begin
            do_write(VEC[i][67:64], VEC[i][69:68], VEC[i][63:32]);
         end else begin
            do_read(VEC[i][67:64], VEC[i][69:68], q);
            check(int'(VEC[i][74:71]), q, VEC[i][31:0]);
         end
      end

      // R11: old value before the capturing edge, new value after it (bank 1)
      @(negedge clk);
      bus_addr  = 4'h0;
      bus_size  = 2'd1;
      bus_wdata = 32'h0000_9999;
      bus_wr    = 1'b1;
      #5 check(11, bus_rdata, 32'h0000_BEEF);
      @(posedge clk);
      #5 check(11, bus_rdata, 32'h0000_9999);
      @(negedge clk);
      bus_wr = 1'b0;

      // R1: reset in mid-run clears bank and storage
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_read(4'hE, 2'd1, q); check(1, q, 32'h0000_3300);
      do_read(4'h0, 2'd1, q); check(1, q, 32'h0000_0000);

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

endmodule